// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus with a 16-bit address and the storage of a plug-in cartridge. Stores that the CPU aims at the read-only program area do not reach memory. The block decodes them as control writes. These writes set the switchable ROM bank, a two-bit secondary bank, a mapping mode, and the enable for the external RAM window. Reads of the program area are turned into a 21-bit physical ROM address, so a 16 KB window can reach any bank of a ROM from 32 KB up to 2 MB.

Accesses to the RAM window at 0xA000-0xBFFF are mapped onto a RAM of 2 KB, 8 KB or 32 KB. While the RAM is switched off, the block withholds the RAM strobes and asks the bus to return 0xFF. The ROM size and RAM size are static configuration codes. The translation is combinational from the address and the stored control state. Control writes take effect at the clock edge that samples the write strobe.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After synchronous reset the switchable bank is 1, the secondary bank is 0, the mode is 0 and the RAM is off. A read at 0x4000 then yields ROM address 0x04000, and a RAM-window read yields the 0xFF override.
- R2: A write anywhere in 0x0000-0x1FFF turns the RAM on when data[3:0] is 4'hA. Any other low nibble turns it off.
- R3: A write in 0x2000-0x3FFF loads the 5-bit switchable bank. Data 0x00 loads 1. Any other value loads data[4:0] ANDed with the size mask. The ROM size codes are 0=32K, 1=64K, 2=128K, 3=256K, 4=512K, 5=1M and 6=2M. Their masks are 0x01, 0x03, 0x07 and 0x0F for codes 0-3, and 0x1F for codes 4-6.
- R4: A write in 0x4000-0x5FFF loads data[1:0] into the secondary bank.
- R5: A write in 0x6000-0x7FFF loads data[0] into the mode flag.
- R6: A read in 0x4000-0x7FFF maps to bank*0x4000 + (address-0x4000). Here bank is the stored bank, with bit 5 taken from secondary[0] for code 5, and bits 6:5 taken from secondary[1:0] for code 6.
- R7: A read in 0x0000-0x3FFF maps to the address itself in mode 0. In mode 1 it maps to zbank*0x4000 + address. zbank is secondary[0]<<5 for code 5, secondary<<5 for code 6, and 0 for other codes.
- R8: rom_addr bits at or above log2 of the configured ROM size are always 0.
- R9: While the RAM is off, a read in 0xA000-0xBFFF raises rd_ovr_en with rd_ovr_data=0xFF, and ram_en and ram_we stay low. A write there has no effect on any RAM.
- R10: The RAM size codes are 0=2K, 1=8K and 2 or 3=32K. ram_addr is (address-0xA000) modulo the size for 2K and 8K. For 32K it is secondary*0x2000 + (address-0xA000) in mode 1, and address-0xA000 in mode 0.
- R11: rom_rd is high only for reads in 0x0000-0x7FFF. ram_en is high only for enabled reads or writes in the RAM window. ram_we is high only for enabled writes there. Addresses outside these windows raise none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| rom_size_code | input | 3 | Static ROM size code (R3) |
| ram_size_code | input | 2 | Static RAM size code (R10) |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_rd | output | 1 | ROM read select |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_en | output | 1 | RAM access select |
| ram_we | output | 1 | RAM write enable |
| rd_ovr_en | output | 1 | Bus must take rd_ovr_data instead of memory |
| rd_ovr_data | output | 8 | Override read value (0xFF) |

## Verification
The bench sweeps every ROM size code against every written bank byte and every secondary value. It therefore covers the zero-to-one substitution, which a faulty design would break by mapping the switchable window onto bank 0. It also covers masking by size: a nonzero value whose masked result is 0 must stay 0, not become 1. For the two large sizes it covers the replacement of the upper bank bits, where a wrong design would mix the secondary bits into smaller ROMs or drop them for large ones. Mode 1 is checked against the fixed window, so a design that always passes the low address through is caught. The RAM checks cover nibble-only enable decoding, a write to a disabled RAM that would leak a write enable, the wrap of 2K and 8K RAMs, and the 32K bank offset that must appear only in mode 1.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    localparam int CPU_AW    = 16;
    localparam int CPU_DW    = 8;
    localparam int WIN_W     = 14;              // 16 KB ROM window offset
    localparam int RAM_WIN_W = 13;              // 8 KB RAM window offset
    localparam int ROM_AW    = 21;              // up to 2 MB
    localparam int RAM_AW    = 15;              // up to 32 KB
    localparam int BANK_W    = 5;
    localparam int SEC_W     = 2;
    localparam int HBANK_W   = ROM_AW - WIN_W;  // full physical bank index
    localparam int SEC_LSB   = BANK_W;          // where secondary bits land

    typedef enum logic [2:0] {
        ROM_32K  = 3'd0,
        ROM_64K  = 3'd1,
        ROM_128K = 3'd2,
        ROM_256K = 3'd3,
        ROM_512K = 3'd4,
        ROM_1M   = 3'd5,
        ROM_2M   = 3'd6,
        ROM_RSVD = 3'd7
    } rom_size_e;

    typedef enum logic [1:0] {
        RAM_2K   = 2'd0,
        RAM_8K   = 2'd1,
        RAM_32K  = 2'd2,
        RAM_32KB = 2'd3
    } ram_size_e;

    typedef enum logic [1:0] {
        RGN_ROM_FIX = 2'd0,
        RGN_ROM_SW  = 2'd1,
        RGN_RAM     = 2'd2,
        RGN_NONE    = 2'd3
    } region_e;

    // control target selected by address bits 14:13 inside 0x0000-0x7FFF
    typedef enum logic [1:0] {
        CTL_RAM_ON = 2'd0,
        CTL_BANK   = 2'd1,
        CTL_SEC    = 2'd2,
        CTL_MODE   = 2'd3
    } ctl_sel_e;

    typedef struct packed {
        logic              ram_on;
        logic [BANK_W-1:0] bank;
        logic [SEC_W-1:0]  sec;
        logic              mode;
    } bank_state_t;

    function automatic logic [BANK_W-1:0] bank_mask(input rom_size_e sz);
        case (sz)
            ROM_32K:  return 5'h01;
            ROM_64K:  return 5'h03;
            ROM_128K: return 5'h07;
            ROM_256K: return 5'h0F;
            default:  return 5'h1F;
        endcase
    endfunction

    function automatic logic [ROM_AW-1:0] rom_span_mask(input rom_size_e sz);
        case (sz)
            ROM_32K:  return 21'h007FFF;
            ROM_64K:  return 21'h00FFFF;
            ROM_128K: return 21'h01FFFF;
            ROM_256K: return 21'h03FFFF;
            ROM_1M:   return 21'h0FFFFF;
            ROM_2M:   return 21'h1FFFFF;
            default:  return 21'h07FFFF;
        endcase
    endfunction

    function automatic region_e decode_region(input logic [CPU_AW-1:0] a);
        if (!a[15])                 return a[14] ? RGN_ROM_SW : RGN_ROM_FIX;
        else if (a[15:13] == 3'b101) return RGN_RAM;
        else                         return RGN_NONE;
    endfunction

endpackage

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_sel,
    input  logic [CPU_DW-1:0] wdata,
    input  rom_size_e         rom_size,
    output bank_state_t       state
);

    logic [BANK_W-1:0] bank_next;

    always_comb begin
        if (wdata == '0) bank_next = BANK_W'(1);
        else             bank_next = wdata[BANK_W-1:0] & bank_mask(rom_size);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '{ram_on: 1'b0, bank: BANK_W'(1), sec: '0, mode: 1'b0};
        end else if (ctl_wr) begin
            case (ctl_sel_e'(ctl_sel))
                CTL_RAM_ON: state.ram_on <= (wdata[3:0] == 4'hA);
                CTL_BANK:   state.bank   <= bank_next;
                CTL_SEC:    state.sec    <= wdata[SEC_W-1:0];
                CTL_MODE:   state.mode   <= wdata[0];
            endcase
        end
    end

endmodule

// File: rtl/cart_rom_map.sv
module cart_rom_map
    import cart_bank_pkg::*;
(
    input  bank_state_t       state,
    input  rom_size_e         rom_size,
    input  logic [WIN_W:0]    addr,      // bit WIN_W selects the switchable window
    output logic [ROM_AW-1:0] rom_addr
);

    logic [HBANK_W-1:0] hi_bank;
    logic [HBANK_W-1:0] zero_bank;
    logic [HBANK_W-1:0] sel_bank;

    always_comb begin
        hi_bank   = {{(HBANK_W-BANK_W){1'b0}}, state.bank};
        zero_bank = '0;
        case (rom_size)
            ROM_1M: begin
                hi_bank[SEC_LSB]   = state.sec[0];
                zero_bank[SEC_LSB] = state.sec[0];
            end
            ROM_2M: begin
                hi_bank[SEC_LSB +: SEC_W]   = state.sec;
                zero_bank[SEC_LSB +: SEC_W] = state.sec;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (addr[WIN_W])     sel_bank = hi_bank;
        else if (state.mode) sel_bank = zero_bank;
        else                 sel_bank = '0;
        rom_addr = {sel_bank, addr[WIN_W-1:0]} & rom_span_mask(rom_size);
    end

endmodule

// File: rtl/cart_ram_map.sv
module cart_ram_map
    import cart_bank_pkg::*;
(
    input  bank_state_t          state,
    input  ram_size_e            ram_size,
    input  logic [RAM_WIN_W-1:0] offset,
    output logic [RAM_AW-1:0]    ram_addr
);

    localparam int SMALL_W = 11;   // 2 KB

    always_comb begin
        case (ram_size)
            RAM_2K:  ram_addr = {{(RAM_AW-SMALL_W){1'b0}}, offset[SMALL_W-1:0]};
            RAM_8K:  ram_addr = {{(RAM_AW-RAM_WIN_W){1'b0}}, offset};
            default: ram_addr = state.mode ? {state.sec, offset}
                                           : {{(RAM_AW-RAM_WIN_W){1'b0}}, offset};
        endcase
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic [CPU_DW-1:0]     cpu_wdata,
    input  logic                  cpu_rd,
    input  logic                  cpu_wr,
    input  logic [2:0]            rom_size_code,
    input  logic [1:0]            ram_size_code,
    output logic [ROM_AW-1:0]     rom_addr,
    output logic                  rom_rd,
    output logic [RAM_AW-1:0]     ram_addr,
    output logic                  ram_en,
    output logic                  ram_we,
    output logic                  rd_ovr_en,
    output logic [CPU_DW-1:0]     rd_ovr_data
);

    region_e     rgn;
    bank_state_t state;
    logic        in_rom;
    logic        in_ram;

    assign rgn    = decode_region(cpu_addr);
    assign in_rom = (rgn == RGN_ROM_FIX) || (rgn == RGN_ROM_SW);
    assign in_ram = (rgn == RGN_RAM);

    cart_bank_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (cpu_wr && in_rom),
        .ctl_sel  (cpu_addr[14:13]),
        .wdata    (cpu_wdata),
        .rom_size (rom_size_e'(rom_size_code)),
        .state    (state)
    );

    cart_rom_map u_rom (
        .state    (state),
        .rom_size (rom_size_e'(rom_size_code)),
        .addr     (cpu_addr[WIN_W:0]),
        .rom_addr (rom_addr)
    );

    cart_ram_map u_ram (
        .state    (state),
        .ram_size (ram_size_e'(ram_size_code)),
        .offset   (cpu_addr[RAM_WIN_W-1:0]),
        .ram_addr (ram_addr)
    );

    assign rom_rd      = cpu_rd && in_rom;
    assign ram_en      = (cpu_rd || cpu_wr) && in_ram && state.ram_on;
    assign ram_we      = cpu_wr && in_ram && state.ram_on;
    assign rd_ovr_en   = cpu_rd && in_ram && !state.ram_on;
    assign rd_ovr_data = rd_ovr_en ? 8'hFF : 8'h00;

endmodule

// File: rtl/cart_bank_chk.sv
module cart_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [2:0]  rom_size_code,
    input logic [1:0]  ram_size_code,
    input logic [20:0] rom_addr,
    input logic        rom_rd,
    input logic [14:0] ram_addr,
    input logic        ram_en,
    input logic        ram_we,
    input logic        rd_ovr_en,
    input logic [7:0]  rd_ovr_data
);

    logic [20:0] span;
    always_comb begin
        case (rom_size_code)
            3'd0: span = 21'h007FFF;
            3'd1: span = 21'h00FFFF;
            3'd2: span = 21'h01FFFF;
            3'd3: span = 21'h03FFFF;
            3'd5: span = 21'h0FFFFF;
            3'd6: span = 21'h1FFFFF;
            default: span = 21'h07FFFF;
        endcase
    end

    a_r1_reset_ram_off: assert property (@(posedge clk)
        rst |=> !ram_en);

    a_r2_enable_nibble: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] == 4'hA) |=> !rd_ovr_en);

    a_r2_disable_nibble: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] != 4'hA) |=> !ram_en);

    a_r6_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b01) |-> rom_addr[13:0] == cpu_addr[13:0]);

    a_r8_rom_in_span: assert property (@(posedge clk) disable iff (rst)
        (rom_addr & ~span) == 21'h0);

    a_r9_override_exclusive: assert property (@(posedge clk) disable iff (rst)
        rd_ovr_en |-> (!ram_en && !ram_we && rd_ovr_data == 8'hFF));

    a_r10_small_ram_wrap: assert property (@(posedge clk) disable iff (rst)
        (ram_en && ram_size_code == 2'd0) |-> ram_addr[14:11] == 4'h0);

    a_r10_ram_offset: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> ram_addr[10:0] == cpu_addr[10:0]);

    a_r11_rom_rd_window: assert property (@(posedge clk) disable iff (rst)
        rom_rd |-> (cpu_rd && !cpu_addr[15]));

    a_r11_we_window: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (cpu_wr && ram_en && cpu_addr[15:13] == 3'b101));

endmodule

bind cart_bank_ctrl cart_bank_chk u_chk (.*);

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [2:0]  rom_size_code = 3'd6;
    logic [1:0]  ram_size_code = 2'd2;
    logic [20:0] rom_addr;
    logic        rom_rd;
    logic [14:0] ram_addr;
    logic        ram_en;
    logic        ram_we;
    logic        rd_ovr_en;
    logic [7:0]  rd_ovr_data;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;   // 250 MHz

    cart_bank_ctrl u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_size_code(rom_size_code),
        .ram_size_code(ram_size_code), .rom_addr(rom_addr), .rom_rd(rom_rd),
        .ram_addr(ram_addr), .ram_en(ram_en), .ram_we(ram_we),
        .rd_ovr_en(rd_ovr_en), .rd_ovr_data(rd_ovr_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
    endtask

    function automatic int e_bank(input int code, input int w);
        int m;
        m = (code >= 4) ? 31 : ((2 << code) - 1);
        return (w == 0) ? 1 : (w & m & 31);
    endfunction

    function automatic int e_span(input int code);
        return (code <= 6) ? ((32768 << code) - 1) : 'h7FFFF;
    endfunction

    function automatic int e_hi(input int code, input int bank, input int sec);
        int hb;
        hb = bank;
        if (code == 5) hb = (hb & ~32) | ((sec & 1) << 5);
        if (code == 6) hb = (hb & ~96) | (sec << 5);
        return hb;
    endfunction

    function automatic int e_zero(input int code, input int sec);
        if (code == 5) return (sec & 1) << 5;
        if (code == 6) return sec << 5;
        return 0;
    endfunction

    function automatic int e_ram(input int rc, input int mode, input int sec, input int a);
        int off;
        off = a - 'hA000;
        if (rc == 0) return off % 2048;
        if (rc == 1) return off % 8192;
        return mode ? (sec * 8192 + off) : off;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        do_rd(16'h4000);
        chk("R1 hi bank one", int'(rom_addr), 'h4000);
        do_rd(16'h0123);
        chk("R1 mode zero", int'(rom_addr), 'h0123);
        do_rd(16'hA000);
        chk("R1 ram off ovr", int'(rd_ovr_en), 1);
        chk("R1 ram off data", int'(rd_ovr_data), 'hFF);
        chk("R1 ram off en", int'(ram_en), 0);

        // R3 R6 R8 switchable window sweep
        for (int code = 0; code < 7; code++) begin
            rom_size_code = 3'(code);
            for (int sec = 0; sec < 4; sec++) begin
                do_wr(16'h4000 + 16'(sec * 97), 8'(sec | 8'hFC));
                for (int w = 0; w < 256; w++) begin
                    int off;
                    int exp;
                    off = (w * 77 + sec * 13) & 'h3FFF;
                    do_wr(16'h2000 + 16'((w * 29) & 'h1FFF), 8'(w));
                    do_rd(16'h4000 + 16'(off));
                    exp = (e_hi(code, e_bank(code, w), sec) * 'h4000 + off) & e_span(code);
                    chk("R3 R6 R8 hi map", int'(rom_addr), exp);
                end
            end
        end

        // R5 R7 fixed window in both modes
        for (int code = 0; code < 7; code++) begin
            rom_size_code = 3'(code);
            for (int sec = 0; sec < 4; sec++) begin
                do_wr(16'h5FFF, 8'(sec));
                do_wr(16'h6000, 8'hFE);
                do_rd(16'h3ABC);
                chk("R5 R7 mode0 fixed", int'(rom_addr), 'h3ABC & e_span(code));
                do_wr(16'h7ABC, 8'h03);
                do_rd(16'h1234);
                chk("R7 mode1 fixed", int'(rom_addr),
                    (e_zero(code, sec) * 'h4000 + 'h1234) & e_span(code));
            end
        end

        // R4 only low two bits
        rom_size_code = 3'd6;
        do_wr(16'h2000, 8'h01);
        do_wr(16'h4ABC, 8'hFE);
        do_rd(16'h4010);
        chk("R4 sec low bits", int'(rom_addr), 'h41 * 'h4000 + 'h10);

        // R2 R9 enable decoding and disabled RAM
        ram_size_code = 2'd2;
        do_wr(16'h6000, 8'h00);
        do_wr(16'h1FFF, 8'h1A);
        do_rd(16'hA000);
        chk("R2 nibble A enables", int'(ram_en), 1);
        chk("R2 no ovr when on", int'(rd_ovr_en), 0);
        do_wr(16'h0000, 8'hA0);
        do_rd(16'hA000);
        chk("R2 A0 disables", int'(rd_ovr_en), 1);
        do_wr(16'h0100, 8'h0A);
        do_wr(16'h0200, 8'h0B);
        do_rd(16'hBFFF);
        chk("R2 0B disables", int'(ram_en), 0);
        chk("R9 ovr data", int'(rd_ovr_data), 'hFF);
        @(negedge clk);
        cpu_addr = 16'hA123; cpu_wdata = 8'h55; cpu_wr = 1'b1; cpu_rd = 1'b0;
        #1;
        chk("R9 disabled write no we", int'(ram_we), 0);
        chk("R9 disabled write no en", int'(ram_en), 0);
        @(negedge clk) cpu_wr = 1'b0;

        // R10 RAM address mapping
        do_wr(16'h0000, 8'h0A);
        for (int rc = 0; rc < 3; rc++) begin
            ram_size_code = 2'(rc);
            for (int mode = 0; mode < 2; mode++) begin
                do_wr(16'h6000, 8'(mode));
                for (int sec = 0; sec < 4; sec++) begin
                    do_wr(16'h4000, 8'(sec));
                    for (int k = 0; k < 5; k++) begin
                        int a;
                        case (k)
                            0: a = 'hA000;
                            1: a = 'hA7FF;
                            2: a = 'hA800;
                            3: a = 'hBFFF;
                            default: a = 'hA000 + ((sec * 1237 + rc * 311) & 'h1FFF);
                        endcase
                        do_rd(16'(a));
                        chk("R10 ram addr", int'(ram_addr), e_ram(rc, mode, sec, a));
                    end
                end
            end
        end

        // R11 strobe windows
        do_rd(16'h8000);
        chk("R11 no rom_rd outside", int'(rom_rd), 0);
        chk("R11 no ram_en outside", int'(ram_en), 0);
        do_rd(16'h7FFF);
        chk("R11 rom_rd in window", int'(rom_rd), 1);
        @(negedge clk);
        cpu_addr = 16'hA010; cpu_wdata = 8'h11; cpu_wr = 1'b1; cpu_rd = 1'b0;
        #1;
        chk("R11 enabled we", int'(ram_we), 1);
        chk("R11 write no rom_rd", int'(rom_rd), 0);
        @(negedge clk);
        cpu_addr = 16'hC000; cpu_wr = 1'b1;
        #1;
        chk("R11 no we outside", int'(ram_we), 0);
        @(negedge clk) cpu_wr = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule